// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block switches the line driver of a half-duplex RS-485 transceiver for one UART transmit channel and decides when the transmit-request interrupt is raised. It sits between the transmit FIFO, the serial shifter and the baud generator. When a frame is waiting, it turns the driver on one bit time before the shifter may begin the start bit. It keeps the driver on while any data remains. When everything has gone out, it holds the driver for a programmable number of bit times and then releases the line.

The interrupt source depends on the configuration. In plain UART use it fires when the FIFO drains. In RS-485 use it follows one of two policies. The large-block policy raises it early, so software can refill the FIFO while bytes are still being shifted. The end-of-frame policy raises it only once the shifter has gone idle with nothing left to send. The interrupt is a level, and it is cleared by a FIFO write or an acknowledge.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: With `mode_485` low, `drv_en` stays low and `start_ok` equals `start_req` in every cycle.
- R2: With `mode_485` high and the controller idle, a pending `start_req` raises `drv_en` on the next `baud_tick`. `start_ok` then pulses on the following `baud_tick`, so the driver leads the start bit by exactly one bit time.
- R3: Once driving, `drv_en` stays high in every cycle in which `shifter_busy` is high or `fifo_level` is non-zero.
- R4: After the shifter is idle and the FIFO is empty, `drv_en` stays high for exactly `dly` further `baud_tick` pulses (1 to 15) and falls after the last of them.
- R5: With `dly` equal to 0, `drv_en` falls in the cycle after the idle-and-empty condition is first seen, without waiting for a `baud_tick`.
- R6: A `start_req` that arrives during the trailing hold cancels the hold. `start_ok` is granted in the same cycle and `drv_en` never drops, so no new one-bit lead is inserted.
- R7: With `mode_485` and `large_blk` high, `tx_irq` rises one cycle after `fifo_level` moves from above `fifo_thresh` to at or below it, and also one cycle after `fifo_level` reaches 0.
- R8: With `mode_485` high and `large_blk` low, threshold crossings do not raise `tx_irq`. It rises one cycle after `shifter_busy` falls while `fifo_level` is 0.
- R9: With `mode_485` low, `tx_irq` rises one cycle after `fifo_level` falls to 0.
- R10: `tx_irq` holds its level until a cycle with `fifo_wr` or `irq_ack` clears it. A set event in the same cycle as a clear leaves `tx_irq` high.
- R11: During reset, `drv_en` and `tx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit-time boundary |
| mode_485 | input | 1 | Enables RS-485 direction control |
| large_blk | input | 1 | Selects the early-refill interrupt policy |
| dly | input | 4 | Trailing hold in bit times (0 to 15) |
| fifo_level | input | LVL_W (7) | Bytes waiting in the transmit FIFO |
| fifo_thresh | input | LVL_W (7) | Refill threshold for the large-block policy |
| fifo_wr | input | 1 | Pulse on a FIFO write; clears the interrupt |
| shifter_busy | input | 1 | Shifter is sending a frame |
| start_req | input | 1 | Shifter wants to start a new frame |
| irq_ack | input | 1 | Interrupt acknowledge |
| drv_en | output | 1 | Transceiver driver enable |
| start_ok | output | 1 | Permission for the shifter to start the frame |
| tx_irq | output | 1 | Transmit-request interrupt level |

## Verification
The interrupt register can receive a set event and a clear in the same cycle. Draining the FIFO to zero produces a set event one cycle after the last byte is taken. The bench provokes the clash by asserting `irq_ack` for exactly that cycle, and then expects `tx_irq` to read high. A second clash sits in the direction logic: a new frame request can arrive while the trailing hold is counting. That case is judged by requiring the start permit in the same cycle, with the driver enable never dropping.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    localparam int DLY_W = 4;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_LEAD = 2'd1,
        DIR_SEND = 2'd2,
        DIR_HOLD = 2'd3
    } dir_state_e;

    typedef struct packed {
        dir_state_e       state;
        logic [DLY_W-1:0] cnt;
    } dir_regs_t;

endpackage

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             mode_en,
    input  logic [DLY_W-1:0] dly,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             shifter_busy,
    input  logic             start_req,
    output logic             drv_en,
    output logic             start_ok
);

    dir_regs_t regs_d, regs_q;
    logic      line_empty;

    assign line_empty = !shifter_busy && (fifo_level == '0);

    always_comb begin
        regs_d   = regs_q;
        start_ok = 1'b0;
        if (!mode_en) begin
            regs_d.state = DIR_IDLE;
            regs_d.cnt   = '0;
            start_ok     = start_req;
        end else begin
            unique case (regs_q.state)
                DIR_IDLE: begin
                    if (start_req && baud_tick) begin
                        regs_d.state = DIR_LEAD;
                    end
                end
                DIR_LEAD: begin
                    if (baud_tick) begin
                        start_ok     = start_req;
                        regs_d.state = DIR_SEND;
                    end
                end
                DIR_SEND: begin
                    start_ok = start_req;
                    if (line_empty) begin
                        if (dly == '0) begin
                            regs_d.state = DIR_IDLE;
                        end else begin
                            regs_d.state = DIR_HOLD;
                            regs_d.cnt   = dly;
                        end
                    end
                end
                DIR_HOLD: begin
                    if (start_req || !line_empty) begin
                        start_ok     = start_req;
                        regs_d.state = DIR_SEND;
                        regs_d.cnt   = '0;
                    end else if (baud_tick) begin
                        if (regs_q.cnt == DLY_W'(1)) begin
                            regs_d.state = DIR_IDLE;
                            regs_d.cnt   = '0;
                        end else begin
                            regs_d.cnt = regs_q.cnt - DLY_W'(1);
                        end
                    end
                end
                default: begin
                    regs_d.state = DIR_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state <= DIR_IDLE;
            regs_q.cnt   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign drv_en = (regs_q.state != DIR_IDLE);

endmodule

// File: rtl/rs485_irq_gen.sv
module rs485_irq_gen #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             large_blk,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] fifo_thresh,
    input  logic             shifter_busy,
    input  logic             fifo_wr,
    input  logic             irq_ack,
    output logic             tx_irq
);

    typedef struct packed {
        logic [LVL_W-1:0] prev_level;
        logic             prev_busy;
        logic             irq;
    } irq_regs_t;

    irq_regs_t regs_d, regs_q;
    logic      drained, crossed, shifter_done, set_evt;

    always_comb begin
        drained      = (regs_q.prev_level != '0) && (fifo_level == '0);
        crossed      = (regs_q.prev_level > fifo_thresh) && (fifo_level <= fifo_thresh);
        shifter_done = regs_q.prev_busy && !shifter_busy && (fifo_level == '0);

        if (!mode_en) begin
            set_evt = drained;
        end else if (large_blk) begin
            set_evt = crossed || drained;
        end else begin
            set_evt = shifter_done;
        end

        regs_d            = regs_q;
        regs_d.prev_level = fifo_level;
        regs_d.prev_busy  = shifter_busy;
        if (set_evt) begin
            regs_d.irq = 1'b1;
        end else if (fifo_wr || irq_ack) begin
            regs_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign tx_irq = regs_q.irq;

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             mode_485,
    input  logic             large_blk,
    input  logic [DLY_W-1:0] dly,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] fifo_thresh,
    input  logic             fifo_wr,
    input  logic             shifter_busy,
    input  logic             start_req,
    input  logic             irq_ack,
    output logic             drv_en,
    output logic             start_ok,
    output logic             tx_irq
);

    rs485_dir_fsm #(.LVL_W(LVL_W)) dir_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .mode_en      (mode_485),
        .dly          (dly),
        .fifo_level   (fifo_level),
        .shifter_busy (shifter_busy),
        .start_req    (start_req),
        .drv_en       (drv_en),
        .start_ok     (start_ok)
    );

    rs485_irq_gen #(.LVL_W(LVL_W)) irq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_en      (mode_485),
        .large_blk    (large_blk),
        .fifo_level   (fifo_level),
        .fifo_thresh  (fifo_thresh),
        .shifter_busy (shifter_busy),
        .fifo_wr      (fifo_wr),
        .irq_ack      (irq_ack),
        .tx_irq       (tx_irq)
    );

endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk #(
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_485,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_wr,
    input logic             shifter_busy,
    input logic             irq_ack,
    input logic             drv_en,
    input logic             start_ok,
    input logic             tx_irq
);

    assert_drv_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_485 |=> !drv_en);

    assert_permit_needs_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_485 && start_ok) |-> drv_en);

    assert_hold_while_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_485 && drv_en && (shifter_busy || fifo_level != '0)) |=> drv_en);

    assert_release_only_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> (!$past(mode_485) ||
                           ($past(fifo_level) == '0 && !$past(shifter_busy))));

    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !irq_ack && !fifo_wr) |=> tx_irq);

endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(.LVL_W(LVL_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_485     (mode_485),
    .fifo_level   (fifo_level),
    .fifo_wr      (fifo_wr),
    .shifter_busy (shifter_busy),
    .irq_ack      (irq_ack),
    .drv_en       (drv_en),
    .start_ok     (start_ok),
    .tx_irq       (tx_irq)
);

// File: tb/rs485_dir_ctrl_tb_top.sv
module rs485_dir_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BAUD_DIV   = 4;
    localparam int FRAME      = 10;
    localparam int LVL_W      = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             baud_tick = 1'b0;
    logic             mode_485 = 1'b0;
    logic             large_blk = 1'b0;
    logic [3:0]       dly = '0;
    logic [LVL_W-1:0] fifo_level;
    logic [LVL_W-1:0] fifo_thresh = '0;
    logic             fifo_wr = 1'b0;
    logic             shifter_busy;
    logic             start_req;
    logic             irq_ack = 1'b0;
    logic             drv_en, start_ok, tx_irq;

    int   fcnt = 0;
    logic busy_m = 1'b0;
    int   bits = 0;
    int   div = 0;
    int   checks = 0;
    int   errors = 0;

    int lead_cnt, trail_cnt, hold_bad, off_bad;
    bit started;

    assign fifo_level   = fcnt[LVL_W-1:0];
    assign shifter_busy = busy_m;
    assign start_req    = !busy_m && (fcnt != 0);

    always #(CLK_PERIOD/2) clk = ~clk;

    rs485_dir_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode_485(mode_485),
        .large_blk(large_blk), .dly(dly), .fifo_level(fifo_level),
        .fifo_thresh(fifo_thresh), .fifo_wr(fifo_wr), .shifter_busy(shifter_busy),
        .start_req(start_req), .irq_ack(irq_ack), .drv_en(drv_en),
        .start_ok(start_ok), .tx_irq(tx_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        logic so_p, tk_p;
        so_p = start_ok;
        tk_p = baud_tick;
        @(posedge clk);
        #1;
        if (so_p) begin
            busy_m = 1'b1; bits = FRAME; fcnt = fcnt - 1;
        end else if (busy_m && tk_p) begin
            bits = bits - 1;
            if (bits == 0) busy_m = 1'b0;
        end
        fifo_wr = 1'b0;
        irq_ack = 1'b0;
        div = (div + 1) % BAUD_DIV;
        baud_tick = (div == 0);
        #1;
    endtask

    task automatic load_fifo(input int n);
        fcnt = fcnt + n;
        fifo_wr = 1'b1;
        #1;
    endtask

    task automatic clear_track();
        lead_cnt = 0; trail_cnt = 0; hold_bad = 0; off_bad = 0; started = 0;
    endtask

    task automatic track();
        if (mode_485) begin
            if (!started && drv_en) lead_cnt++;
            if (start_ok) started = 1;
            if (started && (busy_m || fcnt != 0)) begin
                trail_cnt = 0;
                if (!drv_en) hold_bad++;
            end else if (started && drv_en && baud_tick) begin
                trail_cnt++;
            end
        end else begin
            if (drv_en) off_bad++;
            if (start_ok != start_req) off_bad++;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            step();
            track();
            if (started && !busy_m && fcnt == 0 && (!drv_en || !mode_485)) break;
        end
    endtask

    task automatic test_reset();
        chk(drv_en == 1'b0, "R11 drv_en", drv_en, 0);
        chk(tx_irq == 1'b0, "R11 tx_irq", tx_irq, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic test_mode_off();
        bit seen = 0;
        mode_485 = 1'b0;
        clear_track();
        load_fifo(3);
        started = 1;
        for (int i = 0; i < 3000; i++) begin
            step();
            track();
            if (!seen && fcnt == 0) begin
                seen = 1;
                chk(tx_irq == 1'b0, "R9 before drain edge", tx_irq, 0);
                step(); track();
                chk(tx_irq == 1'b1, "R9 rise after drain", tx_irq, 1);
            end
            if (seen && !busy_m) break;
        end
        chk(off_bad == 0, "R1 no drive and pass-through", off_bad, 0);
        // write clears, then set and acknowledge collide
        load_fifo(1);
        step();
        chk(tx_irq == 1'b0, "R10 write clears", tx_irq, 0);
        irq_ack = 1'b1;
        step();
        chk(tx_irq == 1'b1, "R10 set wins over ack", tx_irq, 1);
        irq_ack = 1'b1;
        step();
        chk(tx_irq == 1'b0, "R10 ack clears", tx_irq, 0);
        for (int i = 0; i < 60 && busy_m; i++) step();
    endtask

    task automatic test_lead();
        mode_485 = 1'b1; large_blk = 1'b0; dly = 4'd2;
        clear_track();
        load_fifo(2);
        drain();
        chk(lead_cnt == BAUD_DIV, "R2 lead one bit time", lead_cnt, BAUD_DIV);
        chk(hold_bad == 0, "R3 held during burst", hold_bad, 0);
        chk(trail_cnt == 2, "R4 trail dly=2", trail_cnt, 2);
        chk(drv_en == 1'b0, "R4 released", drv_en, 0);
    endtask

    task automatic test_trail_all();
        for (int d = 0; d < 16; d++) begin
            dly = 4'(d);
            clear_track();
            load_fifo(1);
            drain();
            chk(trail_cnt == d, (d == 0) ? "R5 zero delay" : "R4 trail hold", trail_cnt, d);
            chk(drv_en == 1'b0, "R4 released after hold", drv_en, 0);
        end
    endtask

    task automatic test_zero_delay_edge();
        int waited = 0;
        dly = 4'd0;
        clear_track();
        load_fifo(1);
        for (int i = 0; i < 3000; i++) begin
            step(); track();
            if (started && !busy_m && fcnt == 0) break;
        end
        chk(drv_en == 1'b1, "R5 still driving when empty first seen", drv_en, 1);
        while (drv_en && waited < 10) begin step(); waited++; end
        chk(waited == 1, "R5 drop without tick", waited, 1);
    endtask

    task automatic test_abort();
        bit so_now;
        dly = 4'd8;
        clear_track();
        load_fifo(1);
        for (int i = 0; i < 3000; i++) begin
            step(); track();
            if (started && trail_cnt == 2) break;
        end
        chk(drv_en == 1'b1, "R6 in trailing hold", drv_en, 1);
        load_fifo(1);
        so_now = start_ok;
        chk(so_now == 1'b1, "R6 permit without lead", so_now, 1);
        drain();
        chk(hold_bad == 0, "R6 driver never dropped", hold_bad, 0);
        chk(trail_cnt == 8, "R6 full hold after resume", trail_cnt, 8);
    endtask

    task automatic test_irq_large();
        bit seen2 = 0, seen0 = 0;
        mode_485 = 1'b1; large_blk = 1'b1; dly = 4'd0; fifo_thresh = 7'd2;
        load_fifo(5);
        step();
        chk(tx_irq == 1'b0, "R10 cleared by write", tx_irq, 0);
        for (int i = 0; i < 3000; i++) begin
            if (!seen2 && fcnt == 2) begin
                seen2 = 1;
                chk(tx_irq == 1'b0, "R7 before crossing edge", tx_irq, 0);
                step();
                chk(tx_irq == 1'b1, "R7 crossing raises irq", tx_irq, 1);
                irq_ack = 1'b1;
                step();
                chk(tx_irq == 1'b0, "R10 ack clears", tx_irq, 0);
            end
            if (seen2 && !seen0 && fcnt == 0) begin
                seen0 = 1;
                chk(tx_irq == 1'b0, "R7 before empty edge", tx_irq, 0);
                step();
                chk(tx_irq == 1'b1, "R7 empty raises irq", tx_irq, 1);
            end
            if (seen0 && !busy_m && !drv_en) break;
            step();
        end
        irq_ack = 1'b1;
        step();
    endtask

    task automatic test_irq_shift();
        bit seen2 = 0;
        mode_485 = 1'b1; large_blk = 1'b0; dly = 4'd0; fifo_thresh = 7'd2;
        load_fifo(3);
        step();
        for (int i = 0; i < 3000; i++) begin
            if (!seen2 && fcnt == 2) begin
                seen2 = 1;
                step();
                chk(tx_irq == 1'b0, "R8 crossing ignored", tx_irq, 0);
            end
            if (seen2 && fcnt == 0 && !busy_m) begin
                chk(tx_irq == 1'b0, "R8 before shifter-done edge", tx_irq, 0);
                step();
                chk(tx_irq == 1'b1, "R8 shifter done raises irq", tx_irq, 1);
                break;
            end
            step();
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        test_reset();
        test_mode_off();
        test_lead();
        test_trail_all();
        test_zero_delay_edge();
        test_abort();
        test_irq_large();
        test_irq_shift();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule